// File: doc/BRIEF.md
# Range Maintenance Request Splitter

This block takes one cache maintenance request over a byte range and turns it into a stream of commands for a downstream range engine. A request gives a start address, an end address that is exclusive, an operation (invalidate, clean or flush) and a write-through override flag. The block emits two kinds of command. A single-line clean-and-invalidate handles a partial edge line. A range command (clean or invalidate) gives an inclusive pair of line addresses. Commands leave through a valid/ready handshake.

Every range command covers at most 1024 bytes and stays inside one 4 KB page. For invalidate, a partial line at either end is first cleaned and invalidated on its own. Clean and flush widen the range to whole lines instead. Under write-through override the lines are never dirty, so range cleans are dropped. When the engine has accepted the last command, the block pulses a completion barrier for one cycle and then becomes free for the next request.

Top module: `rl_range_splitter`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0 and done is 0.
- R2: For invalidate (req_op 0) with a start that is not line aligned, the first command is opcode 0 (single clean-invalidate) with first and last both equal to the start rounded down to 32 bytes. Range commands then begin at the next line boundary.
- R3: For invalidate with an end that is not line aligned, a single clean-invalidate (opcode 0) at the end rounded down follows any head command. Range commands then stop below that line. A request whose start and end fall in the same line gives two single-line commands and no range command.
- R4: For clean (req_op 1) and flush (req_op 2), the start is rounded down and the end is rounded up to a 32-byte boundary. No single-line commands are made.
- R5: A range command uses opcode 1 for clean and opcode 2 for invalidate. Its first and last are line aligned, and last equals the chunk's exclusive end minus 32.
- R6: Each chunk ends at the smallest of: the aligned request end, chunk start plus 1024, and the next 4 KB page boundary. Chunks follow each other with no gap and cover the aligned range.
- R7: first and last of a range command lie in the same 4 KB page.
- R8: For flush without override, each chunk gives a range clean and then a range invalidate with the same first and last.
- R9: With req_wt set, a clean request emits no command, and a flush request emits only range invalidates.
- R10: After the last command is accepted, done is 1 for exactly one cycle while cmd_valid is 0. A request that leaves no lines after alignment, or that uses the reserved req_op 3, gives only the barrier.
- R11: A request is taken only while req_ready is 1. req_ready is 0 from the cycle after acceptance through the barrier cycle.
- R12: While cmd_valid is 1 and cmd_ready is 0, cmd_valid stays 1 and the command fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_start | input | 32 | First byte of the range |
| req_end | input | 32 | Byte after the last byte of the range |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 reserved |
| req_wt | input | 1 | Write-through override |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_opcode | output | 2 | 0 single clean-invalidate, 1 range clean, 2 range invalidate |
| cmd_first | output | 32 | First line address |
| cmd_last | output | 32 | Last line address, inclusive |
| done | output | 1 | Completion barrier pulse |

## Verification
The properties assume that req_end is never below req_start and that the range does not wrap past the top of the address space. They also assume that req_valid is sampled only at idle, which the handshake itself enforces. The directed requests all keep end at or above start and stay well below the top address. cmd_ready is stalled in a fixed pattern during some requests, so the hold and pairing properties are exercised under backpressure.

// File: rtl/rls_pkg.sv
package rls_pkg;

   typedef enum logic [1:0] {
      RQ_INV   = 2'd0,
      RQ_CLEAN = 2'd1,
      RQ_FLUSH = 2'd2,
      RQ_RSVD  = 2'd3
   } rq_op_e;

   typedef enum logic [1:0] {
      CM_LINE_CI  = 2'd0,
      CM_RANGE_CL = 2'd1,
      CM_RANGE_IV = 2'd2
   } cm_op_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_HEAD = 3'd1,
      ST_TAIL = 3'd2,
      ST_RCLN = 3'd3,
      ST_RINV = 3'd4,
      ST_BAR  = 3'd5
   } seq_st_e;

endpackage

// File: rtl/rls_edge_decode.sv
module rls_edge_decode #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32
) (
   input  logic [ADDR_W-1:0] start_i,
   input  logic [ADDR_W-1:0] end_i,
   input  logic [1:0]        op_i,
   input  logic              wt_i,
   output logic              head_o,
   output logic              tail_o,
   output logic [ADDR_W-1:0] head_addr_o,
   output logic [ADDR_W-1:0] tail_addr_o,
   output logic [ADDR_W:0]   cur_o,
   output logic [ADDR_W:0]   lim_o,
   output logic              range_o,
   output logic              entry_clean_o,
   output logic              pair_o
);
   import rls_pkg::*;

   localparam int LINE_LSB = $clog2(LINE_BYTES);
   localparam int PW       = ADDR_W + 1;

   logic            is_inv, is_clean, is_flush;
   logic [ADDR_W-1:0] s_down, e_down;
   logic [PW-1:0]   e_up_raw, e_up, cur_inv;

   assign is_inv   = (rq_op_e'(op_i) == RQ_INV);
   assign is_clean = (rq_op_e'(op_i) == RQ_CLEAN);
   assign is_flush = (rq_op_e'(op_i) == RQ_FLUSH);

   assign s_down = {start_i[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
   assign e_down = {end_i[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};

   // edge lines only get special handling on invalidate
   assign head_o      = is_inv && (|start_i[LINE_LSB-1:0]);
   assign tail_o      = is_inv && (|end_i[LINE_LSB-1:0]);
   assign head_addr_o = s_down;
   assign tail_addr_o = e_down;

   assign e_up_raw = {1'b0, end_i} + PW'(LINE_BYTES - 1);
   assign e_up     = {e_up_raw[PW-1:LINE_LSB], {LINE_LSB{1'b0}}};
   assign cur_inv  = {1'b0, s_down} + (head_o ? PW'(LINE_BYTES) : PW'(0));

   assign cur_o = is_inv ? cur_inv : {1'b0, s_down};
   assign lim_o = is_inv ? {1'b0, e_down} : e_up;

   assign range_o       = (cur_o < lim_o) && !(is_clean && wt_i)
                          && (is_inv || is_clean || is_flush);
   assign entry_clean_o = (is_clean || is_flush) && !wt_i;
   assign pair_o        = is_flush && !wt_i;

endmodule

// File: rtl/rls_chunk_bound.sv
module rls_chunk_bound #(
   parameter int ADDR_W     = 32,
   parameter int MAX_BYTES  = 1024,
   parameter int PAGE_BYTES = 4096
) (
   input  logic [ADDR_W:0] cur_i,
   input  logic [ADDR_W:0] lim_i,
   output logic [ADDR_W:0] cend_o,
   output logic            last_o
);
   localparam int PW       = ADDR_W + 1;
   localparam int PAGE_LSB = $clog2(PAGE_BYTES);
   localparam logic [PW-PAGE_LSB-1:0] PG_ONE = 1;

   logic [PW-1:0] page_nxt, bound_a;

   assign page_nxt = {cur_i[PW-1:PAGE_LSB] + PG_ONE, {PAGE_LSB{1'b0}}};
   assign bound_a  = (lim_i < page_nxt) ? lim_i : page_nxt;

   generate
      if (MAX_BYTES < PAGE_BYTES) begin : g_capped
         logic [PW-1:0] cap;
         assign cap    = cur_i + PW'(MAX_BYTES);
         assign cend_o = (bound_a < cap) ? bound_a : cap;
      end else begin : g_page_only
         // a page bound always falls within MAX_BYTES of an aligned start
         assign cend_o = bound_a;
      end
   endgenerate

   assign last_o = (cend_o == lim_i);

endmodule

// File: rtl/rls_sequencer.sv
module rls_sequencer #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              d_head,
   input  logic              d_tail,
   input  logic [ADDR_W-1:0] d_head_addr,
   input  logic [ADDR_W-1:0] d_tail_addr,
   input  logic [ADDR_W:0]   d_cur,
   input  logic [ADDR_W:0]   d_lim,
   input  logic              d_range,
   input  logic              d_entry_clean,
   input  logic              d_pair,
   input  logic [ADDR_W:0]   c_end,
   input  logic              c_last,
   output logic [ADDR_W:0]   cur_o,
   output logic [ADDR_W:0]   lim_o,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [1:0]        cmd_opcode,
   output logic [ADDR_W-1:0] cmd_first,
   output logic [ADDR_W-1:0] cmd_last,
   output logic              done
);
   import rls_pkg::*;

   localparam int PW = ADDR_W + 1;

   seq_st_e           st_q, st_n, entry_st, after_tail;
   logic [ADDR_W-1:0] head_q, tail_q;
   logic [PW-1:0]     cur_q, lim_q;
   logic              tail_pend_q, range_q, entry_clean_q, pair_q;
   logic              fire, acc;
   logic [PW-1:0]     rng_last;

   assign req_ready = (st_q == ST_IDLE);
   assign fire      = req_valid && req_ready;
   assign cmd_valid = (st_q == ST_HEAD) || (st_q == ST_TAIL)
                      || (st_q == ST_RCLN) || (st_q == ST_RINV);
   assign acc       = cmd_valid && cmd_ready;
   assign done      = (st_q == ST_BAR);

   assign entry_st   = d_entry_clean ? ST_RCLN : ST_RINV;
   assign after_tail = range_q ? (entry_clean_q ? ST_RCLN : ST_RINV) : ST_BAR;

   always_comb begin
      st_n = st_q;
      unique case (st_q)
         ST_IDLE: if (fire) begin
            if (d_head)       st_n = ST_HEAD;
            else if (d_tail)  st_n = ST_TAIL;
            else if (d_range) st_n = entry_st;
            else              st_n = ST_BAR;
         end
         ST_HEAD: if (cmd_ready) st_n = tail_pend_q ? ST_TAIL : after_tail;
         ST_TAIL: if (cmd_ready) st_n = after_tail;
         ST_RCLN: if (cmd_ready) begin
            if (pair_q)      st_n = ST_RINV;
            else if (c_last) st_n = ST_BAR;
            else             st_n = ST_RCLN;
         end
         ST_RINV: if (cmd_ready) begin
            if (c_last)      st_n = ST_BAR;
            else if (pair_q) st_n = ST_RCLN;
            else             st_n = ST_RINV;
         end
         ST_BAR:  st_n = ST_IDLE;
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= ST_IDLE;
         head_q        <= '0;
         tail_q        <= '0;
         cur_q         <= '0;
         lim_q         <= '0;
         tail_pend_q   <= 1'b0;
         range_q       <= 1'b0;
         entry_clean_q <= 1'b0;
         pair_q        <= 1'b0;
      end else begin
         st_q <= st_n;
         if (fire) begin
            head_q        <= d_head_addr;
            tail_q        <= d_tail_addr;
            cur_q         <= d_cur;
            lim_q         <= d_lim;
            tail_pend_q   <= d_tail;
            range_q       <= d_range;
            entry_clean_q <= d_entry_clean;
            pair_q        <= d_pair;
         end else if (acc && ((st_q == ST_RINV) || (st_q == ST_RCLN && !pair_q))) begin
            cur_q <= c_end;
         end
      end
   end

   assign rng_last = c_end - PW'(LINE_BYTES);

   always_comb begin
      cmd_opcode = CM_LINE_CI;
      cmd_first  = cur_q[ADDR_W-1:0];
      cmd_last   = rng_last[ADDR_W-1:0];
      unique case (st_q)
         ST_HEAD: begin cmd_first = head_q; cmd_last = head_q; end
         ST_TAIL: begin cmd_first = tail_q; cmd_last = tail_q; end
         ST_RCLN: cmd_opcode = CM_RANGE_CL;
         ST_RINV: cmd_opcode = CM_RANGE_IV;
         default: ;
      endcase
   end

   assign cur_o = cur_q;
   assign lim_o = lim_q;

endmodule

// File: rtl/rl_range_splitter.sv
module rl_range_splitter #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int MAX_BYTES  = 1024,
   parameter int PAGE_BYTES = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_start,
   input  logic [ADDR_W-1:0] req_end,
   input  logic [1:0]        req_op,
   input  logic              req_wt,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [1:0]        cmd_opcode,
   output logic [ADDR_W-1:0] cmd_first,
   output logic [ADDR_W-1:0] cmd_last,
   output logic              done
);
   localparam int PW = ADDR_W + 1;

   if ((LINE_BYTES < 2) || ((LINE_BYTES & (LINE_BYTES - 1)) != 0)) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < LINE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two not below LINE_BYTES");
   end
   if ((MAX_BYTES % LINE_BYTES) != 0 || MAX_BYTES < LINE_BYTES) begin : g_bad_max
      $error("MAX_BYTES must be a nonzero multiple of LINE_BYTES");
   end
   if (PAGE_BYTES >= (64'd1 << ADDR_W)) begin : g_bad_addr
      $error("PAGE_BYTES must be smaller than the address space");
   end

   logic              d_head, d_tail, d_range, d_entry_clean, d_pair, c_last;
   logic [ADDR_W-1:0] d_head_addr, d_tail_addr;
   logic [PW-1:0]     d_cur, d_lim, cur_q, lim_q, c_end;

   rls_edge_decode #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) i_dec (
      .start_i      (req_start),
      .end_i        (req_end),
      .op_i         (req_op),
      .wt_i         (req_wt),
      .head_o       (d_head),
      .tail_o       (d_tail),
      .head_addr_o  (d_head_addr),
      .tail_addr_o  (d_tail_addr),
      .cur_o        (d_cur),
      .lim_o        (d_lim),
      .range_o      (d_range),
      .entry_clean_o(d_entry_clean),
      .pair_o       (d_pair)
   );

   rls_chunk_bound #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES),
                     .PAGE_BYTES(PAGE_BYTES)) i_chunk (
      .cur_i (cur_q),
      .lim_i (lim_q),
      .cend_o(c_end),
      .last_o(c_last)
   );

   rls_sequencer #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .d_head       (d_head),
      .d_tail       (d_tail),
      .d_head_addr  (d_head_addr),
      .d_tail_addr  (d_tail_addr),
      .d_cur        (d_cur),
      .d_lim        (d_lim),
      .d_range      (d_range),
      .d_entry_clean(d_entry_clean),
      .d_pair       (d_pair),
      .c_end        (c_end),
      .c_last       (c_last),
      .cur_o        (cur_q),
      .lim_o        (lim_q),
      .cmd_valid    (cmd_valid),
      .cmd_ready    (cmd_ready),
      .cmd_opcode   (cmd_opcode),
      .cmd_first    (cmd_first),
      .cmd_last     (cmd_last),
      .done         (done)
   );

endmodule

// File: rtl/rls_checker.sv
module rls_checker #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int MAX_BYTES  = 1024,
   parameter int PAGE_BYTES = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_op,
   input logic              req_wt,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [1:0]        cmd_opcode,
   input logic [ADDR_W-1:0] cmd_first,
   input logic [ADDR_W-1:0] cmd_last,
   input logic              done
);
   localparam int LINE_LSB = $clog2(LINE_BYTES);
   localparam int PAGE_LSB = $clog2(PAGE_BYTES);

   logic wt_q, pair_q, is_rng;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wt_q   <= 1'b0;
         pair_q <= 1'b0;
      end else if (req_valid && req_ready) begin
         wt_q   <= req_wt;
         pair_q <= (req_op == 2'd2) && !req_wt;
      end
   end

   assign is_rng = cmd_valid && (cmd_opcode != 2'd0);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !cmd_valid && !done);

   a_r2_single_line: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_opcode == 2'd0 |->
         cmd_first == cmd_last && cmd_first[LINE_LSB-1:0] == '0);

   a_r5_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      is_rng |-> cmd_first[LINE_LSB-1:0] == '0 && cmd_last[LINE_LSB-1:0] == '0
                 && cmd_opcode != 2'd3);

   a_r6_chunk_cap: assert property (@(posedge clk) disable iff (!rst_n)
      is_rng |-> cmd_last >= cmd_first
                 && (cmd_last - cmd_first) <= ADDR_W'(MAX_BYTES - LINE_BYTES));

   a_r7_same_page: assert property (@(posedge clk) disable iff (!rst_n)
      is_rng |-> cmd_first[ADDR_W-1:PAGE_LSB] == cmd_last[ADDR_W-1:PAGE_LSB]);

   a_r8_flush_pair: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready && cmd_opcode == 2'd1 && pair_q |=>
         cmd_valid && cmd_opcode == 2'd2 && $stable(cmd_first) && $stable(cmd_last));

   a_r9_no_clean_wt: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && wt_q |-> cmd_opcode != 2'd1);

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cmd_valid && !req_ready);

   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_opcode)
                                  && $stable(cmd_first) && $stable(cmd_last));

endmodule

bind rl_range_splitter rls_checker #(
   .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
   .MAX_BYTES(MAX_BYTES), .PAGE_BYTES(PAGE_BYTES)
) i_rls_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_op    (req_op),
   .req_wt    (req_wt),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_opcode(cmd_opcode),
   .cmd_first (cmd_first),
   .cmd_last  (cmd_last),
   .done      (done)
);

// File: tb/test_rl_range_splitter.sv
`timescale 1ns/1ps
module test_rl_range_splitter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_start = '0;
   logic [31:0] req_end = '0;
   logic [1:0]  req_op = '0;
   logic        req_wt = 1'b0;
   logic        cmd_valid;
   logic        cmd_ready = 1'b1;
   logic [1:0]  cmd_opcode;
   logic [31:0] cmd_first, cmd_last;
   logic        done;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;
   int cyc = 0;

   longint exp_op[64], exp_f[64], exp_l[64];
   int     exp_n;
   longint got_op[64], got_f[64], got_l[64];
   int     got_n;

   always #2 clk = ~clk;

   rl_range_splitter i_rl_range_splitter (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_start(req_start), .req_end(req_end),
      .req_op(req_op), .req_wt(req_wt),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_opcode(cmd_opcode), .cmd_first(cmd_first),
      .cmd_last(cmd_last), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
      end
   endtask

   function automatic longint chunk_end(input longint s, input longint e);
      longint re, pn;
      re = e;
      if (re > s + 1024) re = s + 1024;
      pn = (s | 64'hFFF) + 1;
      if (re > pn) re = pn;
      return re;
   endfunction

   task automatic add_exp(input longint op, input longint f, input longint l);
      exp_op[exp_n] = op; exp_f[exp_n] = f; exp_l[exp_n] = l;
      exp_n++;
   endtask

   task automatic build_exp(input longint s0, input longint e0, input int op, input bit wt);
      longint s, e, re;
      longint lm = ~longint'(31);
      s = s0; e = e0; exp_n = 0;
      if (op == 0) begin
         if ((s & 31) != 0) begin add_exp(0, s & lm, s & lm); s = (s | 31) + 1; end
         if ((e & 31) != 0) begin add_exp(0, e & lm, e & lm); e = e & lm; end
         while (s < e) begin re = chunk_end(s, e); add_exp(2, s, re - 32); s = re; end
      end else if (op == 1 || op == 2) begin
         s = s & lm; e = (e + 31) & lm;
         if (!(op == 1 && wt)) begin
            while (s < e) begin
               re = chunk_end(s, e);
               if (!wt) add_exp(1, s, re - 32);
               if (op == 2) add_exp(2, s, re - 32);
               s = re;
            end
         end
      end
   endtask

   // drive one request, collect the command stream, compare with the model
   task automatic run_req(input longint s, input longint e, input int op,
                          input bit wt, input bit stall, input string req);
      bit seen_done = 0, prev_hold = 0, rdy;
      int guard = 0;
      logic [1:0] p_op; logic [31:0] p_f, p_l;
      build_exp(s, e, op, wt);
      got_n = 0;
      @(negedge clk);
      req_start = 32'(s); req_end = 32'(e); req_op = 2'(op); req_wt = wt;
      req_valid = 1'b1;
      chk(req_ready == 1'b1, "R11", "ready before request", req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R11", "busy after accept", req_ready, 0);
      while (!seen_done && guard < 5000) begin
         if (prev_hold)
            chk(cmd_valid && cmd_opcode == p_op && cmd_first == p_f && cmd_last == p_l,
                "R12", "held command", {cmd_opcode, cmd_first}, {p_op, p_f});
         if (done) begin
            seen_done = 1;
            chk(!cmd_valid, "R10", "barrier alone", cmd_valid, 0);
            prev_hold = 0;
         end else begin
            rdy = stall ? ((cyc % 3) != 1) : 1'b1;
            cmd_ready = rdy;
            if (cmd_valid && rdy && got_n < 64) begin
               got_op[got_n] = cmd_opcode; got_f[got_n] = cmd_first; got_l[got_n] = cmd_last;
               got_n++;
            end
            prev_hold = cmd_valid && !rdy;
            p_op = cmd_opcode; p_f = cmd_first; p_l = cmd_last;
         end
         cyc++; guard++;
         @(negedge clk);
      end
      cmd_ready = 1'b1;
      chk(seen_done, "R10", "barrier seen", seen_done, 1);
      chk(!done, "R10", "barrier one cycle", done, 0);
      chk(req_ready, "R11", "idle after barrier", req_ready, 1);
      chk(got_n == exp_n, req, "command count", got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++) begin
         chk(got_op[i] == exp_op[i], req, "opcode", got_op[i], exp_op[i]);
         chk(got_f[i] == exp_f[i], req, "first", got_f[i], exp_f[i]);
         chk(got_l[i] == exp_l[i], req, "last", got_l[i], exp_l[i]);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
      chk(cmd_valid == 1'b0, "R1", "cmd_valid", cmd_valid, 0);
      chk(done == 1'b0, "R1", "done", done, 0);
   endtask

   task automatic t_inv_aligned;     run_req(64'h1000, 64'h1100, 0, 0, 0, "R5");            endtask
   task automatic t_inv_partial;     run_req(64'h1004, 64'h1468, 0, 0, 1, "R2/R3");         endtask
   task automatic t_inv_same_line;   run_req(64'h2004, 64'h2010, 0, 0, 0, "R3");            endtask
   task automatic t_clean_cross;     run_req(64'h0F10, 64'h1A05, 1, 0, 1, "R4/R6/R7");      endtask
   task automatic t_flush_pairs;     run_req(64'h3000, 64'h3C00, 2, 0, 1, "R8/R5");         endtask
   task automatic t_clean_wt;        run_req(64'h5000, 64'h5800, 1, 1, 0, "R9");            endtask
   task automatic t_flush_wt;        run_req(64'h5F00, 64'h6500, 2, 1, 0, "R9");            endtask
   task automatic t_empty;           run_req(64'h8000, 64'h8000, 0, 0, 0, "R10");           endtask
   task automatic t_reserved;        run_req(64'h8000, 64'h9000, 3, 0, 0, "R10");           endtask
   task automatic t_inv_big;         run_req(64'h07E0, 64'h2040, 0, 0, 1, "R6/R7");         endtask
   task automatic t_flush_unaligned; run_req(64'h0FF8, 64'h1009, 2, 0, 0, "R4/R8");         endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_inv_aligned();
      t_inv_partial();
      t_inv_same_line();
      t_clean_cross();
      t_flush_pairs();
      t_clean_wt();
      t_flush_wt();
      t_empty();
      t_reserved();
      t_inv_big();
      t_flush_unaligned();
      finish_run();
   end

endmodule